// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block performs trap entry for a core with three privilege levels: user, supervisor and machine. A trap request lasts one cycle and carries an interrupt flag, a cause code, the address of the trapping instruction and a trap value. In that cycle the block decides which level services the trap and commits all of that level's state on a single clock edge. It loads the level's cause, exception PC and trap value registers, stacks the level's status bits and switches the current privilege. It also emits a one-cycle redirect pulse with the handler address. The handler address comes from the selected level's trap-vector input.

The delegation masks and trap-vector bases are inputs from the surrounding CSR file. A context-load port lets the trap-return and CSR logic outside the block set the current privilege and status word. An active-low asynchronous reset puts the block in the machine-level reset state and presents a fixed reset vector as the next PC.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst_ni` is low, the block holds its reset state: privilege machine (3), status word zero (MIE and MPRV in particular), all cause, EPC and trap-value registers zero, `next_pc_o` equal to parameter `RESET_VEC`, and `redirect_o` low. A trap request presented while reset is low leaves no trace after reset is released.
- R2: The privilege encoding is user = 0, supervisor = 1, machine = 3. By default the trap goes to machine. A trap taken in machine mode always stays in machine.
- R3: From supervisor or user, a trap goes to supervisor when bit `code` of the machine delegation mask is set. Interrupts use `m_ideleg_i` and exceptions use `m_edeleg_i`; the mask of the other kind has no effect.
- R4: From user, a trap goes to user when bit `code` of the supervisor delegation mask is set (`s_ideleg_i` for interrupts, `s_edeleg_i` for exceptions), whatever the machine mask holds. From supervisor, the supervisor mask has no effect.
- R5: The target level's cause register receives the interrupt flag in bit XLEN-1 and the cause code in the low bits, with zeros between. The registers of the other levels keep their values. Level index in the `*_o` arrays is 0 = user, 1 = supervisor, 2 = machine.
- R6: The target level's EPC register receives `trap_pc_i` and its trap-value register receives `trap_val_i`.
- R7: The status word is packed, from MSB down, as {mprv, mpp[1:0], spp, mpie, spie, upie, mie, sie, uie}. Entry to supervisor sets spp to the old privilege bit 0, spie to the old sie, and clears sie. Entry to user sets upie to the old uie and clears uie.
- R8: Entry to machine sets mpp to the old privilege, sets mpie to the old mie, and clears mie.
- R9: The handler base is the selected trap-vector input with bits 1:0 cleared. For an interrupt whose vector input has bits 1:0 equal to 1, the handler address is base + 4*code. In every other case it is the base.
- R10: One clock edge after a trap request, `redirect_o` is high for exactly one cycle and `next_pc_o` holds the handler address. Privilege, status and level registers change on that same edge. Without a request, `redirect_o` stays low.
- R11: `ctx_wr_i` loads privilege and status from `ctx_priv_i` and `ctx_status_i` on the next edge; the value 2 loads as machine. When a trap request arrives in the same cycle, the trap wins and is computed from the old state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_req_i | input | 1 | One-cycle trap request |
| trap_irq_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_code_i | input | CODE_W | Cause code |
| trap_pc_i | input | XLEN | Address of the trapping instruction |
| trap_val_i | input | XLEN | Trap value |
| m_ideleg_i | input | 2**CODE_W | Machine interrupt delegation mask |
| m_edeleg_i | input | 2**CODE_W | Machine exception delegation mask |
| s_ideleg_i | input | 2**CODE_W | Supervisor interrupt delegation mask |
| s_edeleg_i | input | 2**CODE_W | Supervisor exception delegation mask |
| m_tvec_i | input | XLEN | Machine trap-vector register |
| s_tvec_i | input | XLEN | Supervisor trap-vector register |
| u_tvec_i | input | XLEN | User trap-vector register |
| ctx_wr_i | input | 1 | Load privilege and status |
| ctx_priv_i | input | 2 | Privilege to load |
| ctx_status_i | input | 10 | Status word to load |
| priv_o | output | 2 | Current privilege |
| status_o | output | 10 | Current status word |
| cause_o | output | 3 x XLEN | Cause registers per level |
| epc_o | output | 3 x XLEN | Exception PC registers per level |
| tval_o | output | 3 x XLEN | Trap-value registers per level |
| redirect_o | output | 1 | One-cycle redirect pulse |
| next_pc_o | output | XLEN | Handler address or reset vector |

## Verification
Traps are raised from each privilege level with the matching mask bit set, with the mask of the other kind (interrupt versus exception) set, and with only the supervisor mask set. Together these separate the two delegation stages and show that the interrupt and exception masks do not cross over. Each trap enters with distinct enable bits set, so copying the wrong enable or the wrong previous privilege gives a visible difference. Vector inputs in modes 0, 1 and 3 are combined with interrupts and exceptions, which separates the vectored offset from the plain base. A context load in the same cycle as a trap shows which of the two takes priority.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  typedef struct packed {
    logic       mprv;
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       upie;
    logic       mie;
    logic       sie;
    logic       uie;
  } status_t;

  localparam int STATUS_W = $bits(status_t);
  localparam int NLVL     = 3;
  localparam int LVL_U    = 0;
  localparam int LVL_S    = 1;
  localparam int LVL_M    = 2;

  function automatic logic [1:0] lvl_priv(input int lvl);
    case (lvl)
      LVL_U:   return PRIV_U;
      LVL_S:   return PRIV_S;
      default: return PRIV_M;
    endcase
  endfunction
endpackage

// File: rtl/trap_deleg.sv
module trap_deleg
  import trap_pkg::*;
#(
  parameter int CODE_W = 5,
  localparam int NCODE = 2 ** CODE_W
) (
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [1:0]        cur_priv_i,
  input  logic [NCODE-1:0]  m_ideleg_i,
  input  logic [NCODE-1:0]  m_edeleg_i,
  input  logic [NCODE-1:0]  s_ideleg_i,
  input  logic [NCODE-1:0]  s_edeleg_i,
  output logic [1:0]        tgt_priv_o
);
  logic [NCODE-1:0] m_mask, s_mask;

  assign m_mask = irq_i ? m_ideleg_i : m_edeleg_i;
  assign s_mask = irq_i ? s_ideleg_i : s_edeleg_i;

  always_comb begin
    tgt_priv_o = PRIV_M;
    if (cur_priv_i != PRIV_M && m_mask[code_i]) tgt_priv_o = PRIV_S;
    if (cur_priv_i == PRIV_U && s_mask[code_i]) tgt_priv_o = PRIV_U;
  end
endmodule

// File: rtl/trap_vec.sv
module trap_vec #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5,
  parameter bit VEC_EN = 1'b1
) (
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   tvec_i,
  output logic [XLEN-1:0]   addr_o
);
  logic [XLEN-1:0] base;

  assign base = {tvec_i[XLEN-1:2], 2'b00};

  generate
    if (VEC_EN) begin : g_vec
      logic [XLEN-1:0] ofs;
      assign ofs    = XLEN'(code_i) << 2;
      assign addr_o = (irq_i && tvec_i[1:0] == 2'b01) ? base + ofs : base;
    end else begin : g_direct
      logic unused_in;
      assign unused_in = irq_i ^ (^code_i);
      assign addr_o    = base;
    end
  endgenerate
endmodule

// File: rtl/trap_lvl_regs.sv
module trap_lvl_regs #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] cause_d_i,
  input  logic [XLEN-1:0] epc_d_i,
  input  logic [XLEN-1:0] tval_d_i,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] tval_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= '0;
      epc_o   <= '0;
      tval_o  <= '0;
    end else if (we_i) begin
      cause_o <= cause_d_i;
      epc_o   <= epc_d_i;
      tval_o  <= tval_d_i;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              CODE_W    = 5,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000,
  parameter bit              VEC_EN    = 1'b1,
  localparam int             NCODE     = 2 ** CODE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      trap_req_i,
  input  logic                      trap_irq_i,
  input  logic [CODE_W-1:0]         trap_code_i,
  input  logic [XLEN-1:0]           trap_pc_i,
  input  logic [XLEN-1:0]           trap_val_i,
  input  logic [NCODE-1:0]          m_ideleg_i,
  input  logic [NCODE-1:0]          m_edeleg_i,
  input  logic [NCODE-1:0]          s_ideleg_i,
  input  logic [NCODE-1:0]          s_edeleg_i,
  input  logic [XLEN-1:0]           m_tvec_i,
  input  logic [XLEN-1:0]           s_tvec_i,
  input  logic [XLEN-1:0]           u_tvec_i,
  input  logic                      ctx_wr_i,
  input  logic [1:0]                ctx_priv_i,
  input  logic [STATUS_W-1:0]       ctx_status_i,
  output logic [1:0]                priv_o,
  output logic [STATUS_W-1:0]       status_o,
  output logic [NLVL-1:0][XLEN-1:0] cause_o,
  output logic [NLVL-1:0][XLEN-1:0] epc_o,
  output logic [NLVL-1:0][XLEN-1:0] tval_o,
  output logic                      redirect_o,
  output logic [XLEN-1:0]           next_pc_o
);
  logic [1:0]      priv_q, priv_n, tgt_priv, ctx_priv;
  status_t         st_q, st_n;
  logic [XLEN-1:0] tvec_sel, handler, cause_d;

  trap_deleg #(.CODE_W(CODE_W)) u_deleg (
    .irq_i      (trap_irq_i),
    .code_i     (trap_code_i),
    .cur_priv_i (priv_q),
    .m_ideleg_i (m_ideleg_i),
    .m_edeleg_i (m_edeleg_i),
    .s_ideleg_i (s_ideleg_i),
    .s_edeleg_i (s_edeleg_i),
    .tgt_priv_o (tgt_priv)
  );

  always_comb begin
    case (tgt_priv)
      PRIV_U:  tvec_sel = u_tvec_i;
      PRIV_S:  tvec_sel = s_tvec_i;
      default: tvec_sel = m_tvec_i;
    endcase
  end

  trap_vec #(.XLEN(XLEN), .CODE_W(CODE_W), .VEC_EN(VEC_EN)) u_vec (
    .irq_i  (trap_irq_i),
    .code_i (trap_code_i),
    .tvec_i (tvec_sel),
    .addr_o (handler)
  );

  assign cause_d = {trap_irq_i, (XLEN-1)'(trap_code_i)};

  generate
    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      logic we;
      assign we = trap_req_i && (tgt_priv == lvl_priv(l));
      trap_lvl_regs #(.XLEN(XLEN)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (we),
        .cause_d_i (cause_d),
        .epc_d_i   (trap_pc_i),
        .tval_d_i  (trap_val_i),
        .cause_o   (cause_o[l]),
        .epc_o     (epc_o[l]),
        .tval_o    (tval_o[l])
      );
    end
  endgenerate

  // reserved encoding 2 is folded onto machine
  assign ctx_priv = (ctx_priv_i == 2'b10) ? PRIV_M : ctx_priv_i;

  always_comb begin
    st_n   = st_q;
    priv_n = priv_q;
    if (ctx_wr_i) begin
      st_n   = status_t'(ctx_status_i);
      priv_n = ctx_priv;
    end
    if (trap_req_i) begin
      st_n   = st_q;
      priv_n = tgt_priv;
      case (tgt_priv)
        PRIV_U: begin
          st_n.upie = st_q.uie;
          st_n.uie  = 1'b0;
        end
        PRIV_S: begin
          st_n.spp  = priv_q[0];
          st_n.spie = st_q.sie;
          st_n.sie  = 1'b0;
        end
        default: begin
          st_n.mpp  = priv_q;
          st_n.mpie = st_q.mie;
          st_n.mie  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q     <= PRIV_M;
      st_q       <= '0;
      redirect_o <= 1'b0;
      next_pc_o  <= RESET_VEC;
    end else begin
      priv_q     <= priv_n;
      st_q       <= st_n;
      redirect_o <= trap_req_i;
      if (trap_req_i) next_pc_o <= handler;
    end
  end

  assign priv_o   = priv_q;
  assign status_o = st_q;
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      trap_req_i,
  input logic                      trap_irq_i,
  input logic [XLEN-1:0]           trap_pc_i,
  input logic [1:0]                priv_o,
  input logic [STATUS_W-1:0]       status_o,
  input logic [NLVL-1:0][XLEN-1:0] epc_o,
  input logic                      redirect_o,
  input logic [XLEN-1:0]           next_pc_o
);
  status_t st;
  assign st = status_t'(status_o);

  p_m_stays_m_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i && priv_o == 2'b11 |=> priv_o == 2'b11);

  p_m_epc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i && priv_o == 2'b11 |=> epc_o[LVL_M] == $past(trap_pc_i));

  p_m_mie_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i && priv_o == 2'b11 |=> !st.mie && st.mpp == 2'b11);

  p_exc_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i && !trap_irq_i |=> next_pc_o[1:0] == 2'b00);

  p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i |=> redirect_o);

  p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_req_i |=> !redirect_o);

  p_priv_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_o != 2'b10);
endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trap_req_i (trap_req_i),
  .trap_irq_i (trap_irq_i),
  .trap_pc_i  (trap_pc_i),
  .priv_o     (priv_o),
  .status_o   (status_o),
  .epc_o      (epc_o),
  .redirect_o (redirect_o),
  .next_pc_o  (next_pc_o)
);

// File: tb/trap_entry_ctrl_bench.sv
module trap_entry_ctrl_bench;
  import trap_pkg::*;

  localparam int              XLEN   = 32;
  localparam int              CODE_W = 5;
  localparam int              NCODE  = 2 ** CODE_W;
  localparam logic [XLEN-1:0] RVEC   = 32'h0000_1000;

  logic                      clk_i = 1'b0;
  logic                      rst_ni = 1'b0;
  logic                      trap_req_i = 1'b0, trap_irq_i = 1'b0;
  logic [CODE_W-1:0]         trap_code_i = '0;
  logic [XLEN-1:0]           trap_pc_i = '0, trap_val_i = '0;
  logic [NCODE-1:0]          m_ideleg_i = '0, m_edeleg_i = '0;
  logic [NCODE-1:0]          s_ideleg_i = '0, s_edeleg_i = '0;
  logic [XLEN-1:0]           m_tvec_i = 32'h8000_0101;
  logic [XLEN-1:0]           s_tvec_i = 32'h4000_0200;
  logic [XLEN-1:0]           u_tvec_i = 32'h2000_0301;
  logic                      ctx_wr_i = 1'b0;
  logic [1:0]                ctx_priv_i = '0;
  logic [STATUS_W-1:0]       ctx_status_i = '0;
  logic [1:0]                priv_o;
  logic [STATUS_W-1:0]       status_o;
  logic [NLVL-1:0][XLEN-1:0] cause_o, epc_o, tval_o;
  logic                      redirect_o;
  logic [XLEN-1:0]           next_pc_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  trap_entry_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_VEC(RVEC)) u_trap_entry_ctrl (
    .clk_i, .rst_ni, .trap_req_i, .trap_irq_i, .trap_code_i, .trap_pc_i, .trap_val_i,
    .m_ideleg_i, .m_edeleg_i, .s_ideleg_i, .s_edeleg_i,
    .m_tvec_i, .s_tvec_i, .u_tvec_i,
    .ctx_wr_i, .ctx_priv_i, .ctx_status_i,
    .priv_o, .status_o, .cause_o, .epc_o, .tval_o, .redirect_o, .next_pc_o
  );

  status_t st;
  assign st = status_t'(status_o);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctx_load(input logic [1:0] p, input status_t s);
    @(negedge clk_i);
    ctx_wr_i = 1'b1; ctx_priv_i = p; ctx_status_i = s;
    @(negedge clk_i);
    ctx_wr_i = 1'b0;
  endtask

  task automatic fire(input logic irq, input int code, input logic [31:0] pc, input logic [31:0] val);
    @(negedge clk_i);
    trap_req_i = 1'b1; trap_irq_i = irq; trap_code_i = CODE_W'(code);
    trap_pc_i = pc; trap_val_i = val;
    @(negedge clk_i);
    trap_req_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 priv", 64'(priv_o), 64'(3));
    chk("R1 status", 64'(status_o), 64'(0));
    chk("R1 mcause", 64'(cause_o[LVL_M]), 64'(0));
    chk("R1 next_pc", 64'(next_pc_o), 64'(RVEC));
    chk("R1 redirect", 64'(redirect_o), 64'(0));
  endtask

  task automatic t_reset_trap;
    @(negedge clk_i);
    rst_ni = 1'b0;
    trap_req_i = 1'b1; trap_irq_i = 1'b0; trap_code_i = 5'd4; trap_pc_i = 32'h9999; trap_val_i = 32'h1;
    @(negedge clk_i);
    trap_req_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 trap in reset: mepc", 64'(epc_o[LVL_M]), 64'(0));
    chk("R1 trap in reset: redirect", 64'(redirect_o), 64'(0));
    chk("R1 trap in reset: next_pc", 64'(next_pc_o), 64'(RVEC));
  endtask

  task automatic t_m_default;
    status_t s = '0;
    s.mie = 1'b1;
    ctx_load(PRIV_M, s);
    fire(1'b0, 2, 32'h1000, 32'hDEAD);
    chk("R2 priv stays M", 64'(priv_o), 64'(3));
    chk("R5 mcause", 64'(cause_o[LVL_M]), 64'(2));
    chk("R6 mepc", 64'(epc_o[LVL_M]), 64'h1000);
    chk("R6 mtval", 64'(tval_o[LVL_M]), 64'hDEAD);
    chk("R8 mpp", 64'(st.mpp), 64'(3));
    chk("R8 mpie", 64'(st.mpie), 64'(1));
    chk("R8 mie", 64'(st.mie), 64'(0));
    chk("R9 exc base", 64'(next_pc_o), 64'h8000_0100);
    chk("R10 pulse", 64'(redirect_o), 64'(1));
    @(negedge clk_i);
    chk("R10 pulse ends", 64'(redirect_o), 64'(0));
  endtask

  task automatic t_deleg_s;
    status_t s = '0;
    s.sie = 1'b1;
    m_edeleg_i = 32'h1 << 5;
    ctx_load(PRIV_S, s);
    fire(1'b0, 5, 32'h2000, 32'h55);
    chk("R3 to S", 64'(priv_o), 64'(1));
    chk("R5 scause", 64'(cause_o[LVL_S]), 64'(5));
    chk("R5 mcause kept", 64'(cause_o[LVL_M]), 64'(2));
    chk("R6 sepc", 64'(epc_o[LVL_S]), 64'h2000);
    chk("R6 stval", 64'(tval_o[LVL_S]), 64'h55);
    chk("R7 spp", 64'(st.spp), 64'(1));
    chk("R7 spie", 64'(st.spie), 64'(1));
    chk("R7 sie", 64'(st.sie), 64'(0));
    chk("R9 s base", 64'(next_pc_o), 64'h4000_0200);
  endtask

  task automatic t_irq_masks;
    m_ideleg_i = 32'h1 << 9;
    ctx_load(PRIV_S, '0);
    fire(1'b1, 5, 32'h2100, 32'h0);
    chk("R3 exc mask ignored for irq", 64'(priv_o), 64'(3));
    chk("R5 irq cause", 64'(cause_o[LVL_M]), 64'h8000_0005);
    chk("R9 vectored", 64'(next_pc_o), 64'h8000_0114);
    ctx_load(PRIV_S, '0);
    fire(1'b1, 9, 32'h2200, 32'h0);
    chk("R3 irq deleg to S", 64'(priv_o), 64'(1));
    chk("R5 s irq cause", 64'(cause_o[LVL_S]), 64'h8000_0009);
    chk("R9 mode0 irq base", 64'(next_pc_o), 64'h4000_0200);
  endtask

  task automatic t_deleg_u;
    status_t s = '0;
    s.uie = 1'b1;
    m_edeleg_i = m_edeleg_i | (32'h1 << 8);
    s_edeleg_i = 32'h1 << 8;
    ctx_load(PRIV_U, s);
    fire(1'b0, 8, 32'h3000, 32'h77);
    chk("R4 to U", 64'(priv_o), 64'(0));
    chk("R5 ucause", 64'(cause_o[LVL_U]), 64'(8));
    chk("R6 uepc", 64'(epc_o[LVL_U]), 64'h3000);
    chk("R7 upie", 64'(st.upie), 64'(1));
    chk("R7 uie", 64'(st.uie), 64'(0));
    chk("R9 u exc base", 64'(next_pc_o), 64'h2000_0300);
  endtask

  task automatic t_sdeleg_only;
    s_edeleg_i = s_edeleg_i | (32'h1 << 3);
    ctx_load(PRIV_U, '0);
    fire(1'b0, 3, 32'h3100, 32'h0);
    chk("R4 s mask alone from U", 64'(priv_o), 64'(0));
    ctx_load(PRIV_S, '0);
    fire(1'b0, 3, 32'h3200, 32'h0);
    chk("R4 s mask ignored from S", 64'(priv_o), 64'(3));
    chk("R8 mpp from S", 64'(st.mpp), 64'(1));
  endtask

  task automatic t_vec;
    m_tvec_i = 32'h8000_0103;
    ctx_load(PRIV_M, '0);
    fire(1'b1, 7, 32'h4000, 32'h0);
    chk("R9 mode3 irq base", 64'(next_pc_o), 64'h8000_0100);
    m_tvec_i = 32'h8000_0101;
    fire(1'b1, 7, 32'h4100, 32'h0);
    chk("R9 mode1 irq vectored", 64'(next_pc_o), 64'h8000_011C);
    fire(1'b0, 7, 32'h4200, 32'h0);
    chk("R9 mode1 exc base", 64'(next_pc_o), 64'h8000_0100);
  endtask

  task automatic t_ctx_vs_trap;
    ctx_load(PRIV_M, '0);
    m_edeleg_i = '0;
    @(negedge clk_i);
    ctx_wr_i = 1'b1; ctx_priv_i = PRIV_U; ctx_status_i = '1;
    trap_req_i = 1'b1; trap_irq_i = 1'b0; trap_code_i = 5'd2; trap_pc_i = 32'h5000; trap_val_i = 32'h0;
    @(negedge clk_i);
    ctx_wr_i = 1'b0; trap_req_i = 1'b0;
    chk("R11 trap wins priv", 64'(priv_o), 64'(3));
    chk("R11 trap wins status", 64'(status_o), 64'({1'b0, 2'b11, 7'b0}));
    ctx_load(2'b10, '0);
    chk("R11 priv 2 loads as M", 64'(priv_o), 64'(3));
    ctx_load(PRIV_S, '0);
    chk("R11 ctx load", 64'(priv_o), 64'(1));
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    t_reset_trap;
    t_m_default;
    t_deleg_s;
    t_irq_masks;
    t_deleg_u;
    t_sdeleg_only;
    t_vec;
    t_ctx_vs_trap;
    done = 1'b1;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run;
    end
  end
endmodule